// File: doc/BRIEF.md
# Ping-Pong Coefficient Side Loader

This block holds the coefficients for a two-column dot-product engine in two complete banks, set A and set B. Each bank keeps one 8-bit shared exponent and ten 8-bit weights for each of the two columns. A select input chooses which bank feeds the compute datapath. The other bank can be rewritten in the background through two narrow byte lanes, so computation never stalls while fresh coefficients arrive.

A load starts when the strobe for one bank rises while the loader is idle. After that start cycle, a fixed run of twelve capture cycles follows, with one byte per lane per cycle. Exponents come first, then one lead-in cycle whose bytes are discarded, then the ten weights in order. The run length does not depend on the strobe. The strobe may fall one cycle before the last byte, and that byte is still stored. The refreshed bank is valid on the outputs from the cycle after the last capture, and the select can switch to it at that point. Each bank has a ready flag. A one-cycle error flag marks a load that was aimed at the bank currently selected for compute.

Top module: `pp_side_loader`

## Requirements
- R1: While `rst` is high at a clock edge, both banks are cleared to zero, `set_ready` becomes 2'b00 and `aim_err` becomes 0, so every coefficient output reads zero for either select value.
- R2: A load starts in a cycle (cycle 1) where the loader is idle and exactly one strobe (`ld_strobe_a` for set A, `ld_strobe_b` for set B) is high after being low in the previous cycle, while the other strobe is low. The lane bytes of cycle 1 are not stored.
- R3: In cycle 2, `side_a` is stored as the column-0 exponent and `side_b` as the column-1 exponent. The bytes of cycle 3 are discarded. In cycles 4 to 13, weight k (k = 1..10) is taken from `side_a` into column 0 and from `side_b` into column 1. Weight k appears at bits [(k-1)*8 +: 8] of `col0_wts` / `col1_wts`.
- R4: A started load always captures exactly twelve cycles (2 to 13), whether its strobe falls in cycle 13, earlier, or right after cycle 1. The byte of cycle 13 is always stored.
- R5: From cycle 14 on, the target bank's ready bit reads 1, and with the select pointing at that bank the outputs show the newly loaded values.
- R6: The target bank's ready bit reads 0 from cycle 2 until the load completes.
- R7: The outputs show set A when `use_set_b` is 0 and set B when it is 1. The change follows the select without a clock edge. A bank that is not being loaded keeps its contents.
- R8: `aim_err` is high for exactly cycle 2 when the bank targeted by an accepted load equals the bank selected by `use_set_b` in cycle 1. The load still completes.
- R9: When both strobes are high in the same cycle while the loader is idle, no load starts: contents and ready flags stay unchanged and `aim_err` stays 0.
- R10: Strobe activity during a running load, on either strobe, neither restarts the load nor starts a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_strobe_a | input | 1 | Load request for set A |
| ld_strobe_b | input | 1 | Load request for set B |
| side_a | input | 8 | Byte lane for column 0 |
| side_b | input | 8 | Byte lane for column 1 |
| use_set_b | input | 1 | Compute select: 0 = set A, 1 = set B |
| col0_wts | output | 80 | Selected bank, column 0 weights |
| col1_wts | output | 80 | Selected bank, column 1 weights |
| col0_exp | output | 8 | Selected bank, column 0 exponent |
| col1_exp | output | 8 | Selected bank, column 1 exponent |
| set_ready | output | 2 | Ready flags, bit 0 = set A, bit 1 = set B |
| aim_err | output | 1 | Load aimed at the live bank (one-cycle pulse) |

## Verification
The properties assume that the strobes and the select are synchronous and change only between clock edges. They place no constraint on the lane bytes. They also assume that a new load is wanted only after its strobe has been low for at least one cycle. The stimulus drives every input at the falling edge and lowers each strobe before the next load begins. Random lane bytes, select values, strobe lengths and stray strobe pulses during a load are mixed with directed cases: both strobes at once, a load aimed at the live bank, and a reset after loading.

// File: rtl/pp_side_pkg.sv
package pp_side_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned WTS_PER_COL = 10;
    localparam int unsigned NUM_COLS    = 2;
    localparam int unsigned NUM_SETS    = 2;
    localparam int unsigned LEAD_SLOTS  = 2;
    localparam int unsigned SEQ_SLOTS   = LEAD_SLOTS + WTS_PER_COL;
    localparam int unsigned SLOT_W      = $clog2(SEQ_SLOTS);
    localparam int unsigned COL_VEC_W   = WTS_PER_COL * BYTE_W;
    localparam int unsigned LANES_W     = NUM_COLS * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t LAST_SLOT = slot_t'(SEQ_SLOTS - 1);

    typedef enum logic [1:0] {
        SK_EXP = 2'd0,
        SK_PAD = 2'd1,
        SK_WT  = 2'd2
    } slot_kind_e;

    typedef struct packed {
        byte_t [NUM_COLS-1:0]                 expo;
        logic  [NUM_COLS-1:0][COL_VEC_W-1:0]  wts;
    } coef_set_t;

    typedef struct packed {
        logic  active;
        logic  target;
        slot_t slot;
    } wr_cmd_t;

    function automatic slot_kind_e kind_of(slot_t s);
        if (s == '0)
            return SK_EXP;
        else if (int'(s) < int'(LEAD_SLOTS))
            return SK_PAD;
        else
            return SK_WT;
    endfunction

    function automatic int wt_pos(slot_t s);
        return int'(s) - int'(LEAD_SLOTS);
    endfunction

endpackage

// File: rtl/pp_load_ctrl.sv
module pp_load_ctrl
    import pp_side_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_a,
    input  logic                strobe_b,
    input  logic                sel_b,
    output wr_cmd_t             cmd,
    output logic [NUM_SETS-1:0] ready,
    output logic                aim_err
);

    logic  prev_a, prev_b;
    logic  busy_q, tgt_q;
    slot_t slot_q;
    logic  rise_a, rise_b, start, start_tgt, at_last;

    always_comb begin
        rise_a    = strobe_a & ~prev_a;
        rise_b    = strobe_b & ~prev_b;
        start     = ~busy_q & ((rise_a & ~strobe_b) | (rise_b & ~strobe_a));
        start_tgt = rise_b & ~strobe_a;
        at_last   = busy_q && (slot_q == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a  <= 1'b0;
            prev_b  <= 1'b0;
            busy_q  <= 1'b0;
            tgt_q   <= 1'b0;
            slot_q  <= '0;
            ready   <= '0;
            aim_err <= 1'b0;
        end else begin
            prev_a  <= strobe_a;
            prev_b  <= strobe_b;
            aim_err <= start && (start_tgt == sel_b);
            if (start) begin
                busy_q           <= 1'b1;
                tgt_q            <= start_tgt;
                slot_q           <= '0;
                ready[start_tgt] <= 1'b0;
            end else if (busy_q) begin
                if (at_last) begin
                    busy_q       <= 1'b0;
                    slot_q       <= '0;
                    ready[tgt_q] <= 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign cmd = '{active: busy_q, target: tgt_q, slot: slot_q};

    AST_BOTH_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && strobe_a && strobe_b) |=> !busy_q) // R9
        else $error("both strobes started a load");

    AST_START_A: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && strobe_a && !prev_a && !strobe_b) |=> (busy_q && slot_q == '0 && !tgt_q && !ready[0])) // R2
        else $error("set A load did not start");

    AST_START_B: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && strobe_b && !prev_b && !strobe_a) |=> (busy_q && slot_q == '0 && tgt_q && !ready[1])) // R6
        else $error("set B load did not start");

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_q && slot_q != LAST_SLOT) |=> (busy_q && slot_q == slot_t'($past(slot_q) + 1'b1))) // R10
        else $error("running load disturbed");

    AST_FINISH_A: assert property (@(posedge clk) disable iff (rst)
        (busy_q && slot_q == LAST_SLOT && !tgt_q) |=> (!busy_q && ready[0])) // R4
        else $error("set A load did not finish");

    AST_FINISH_B: assert property (@(posedge clk) disable iff (rst)
        (busy_q && slot_q == LAST_SLOT && tgt_q) |=> (!busy_q && ready[1])) // R5
        else $error("set B load did not finish");

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        aim_err |-> (busy_q && slot_q == '0 && tgt_q == $past(sel_b))) // R8
        else $error("aim error outside cycle 2");

endmodule

// File: rtl/pp_col_store.sv
module pp_col_store
    import pp_side_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  slot_t                slot,
    input  byte_t                din,
    output byte_t                expo,
    output logic [COL_VEC_W-1:0] wts
);

    slot_kind_e kind;
    byte_t      exp_q;

    assign kind = kind_of(slot);

    always_ff @(posedge clk) begin
        if (rst)
            exp_q <= '0;
        else if (wr_en && kind == SK_EXP)
            exp_q <= din;
    end

    assign expo = exp_q;

    for (genvar i = 0; i < int'(WTS_PER_COL); i++) begin : g_cell
        byte_t cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (wr_en && kind == SK_WT && wt_pos(slot) == i)
                cell_q <= din;
        end
        assign wts[i*BYTE_W +: BYTE_W] = cell_q;
    end

    AST_PAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == SK_PAD) |=> ($stable(expo) && $stable(wts))) // R3
        else $error("lead-in pad byte stored");

    AST_EXP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == SK_EXP) |=> (expo == $past(din))) // R3
        else $error("exponent not captured");

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(expo) && $stable(wts))) // R7
        else $error("column changed without write");

endmodule

// File: rtl/pp_buf_set.sv
module pp_buf_set
    import pp_side_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  slot_t              slot,
    input  logic [LANES_W-1:0] lanes,
    output coef_set_t          contents
);

    byte_t [NUM_COLS-1:0]                expo_v;
    logic  [NUM_COLS-1:0][COL_VEC_W-1:0] wts_v;

    for (genvar c = 0; c < int'(NUM_COLS); c++) begin : g_col
        pp_col_store u_col (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_en),
            .slot  (slot),
            .din   (lanes[c*BYTE_W +: BYTE_W]),
            .expo  (expo_v[c]),
            .wts   (wts_v[c])
        );
    end

    assign contents.expo = expo_v;
    assign contents.wts  = wts_v;

endmodule

// File: rtl/pp_out_sel.sv
module pp_out_sel
    import pp_side_pkg::*;
(
    input  logic      sel_b,
    input  coef_set_t set_a,
    input  coef_set_t set_b,
    output coef_set_t live
);

    assign live = sel_b ? set_b : set_a;

endmodule

// File: rtl/pp_side_loader.sv
module pp_side_loader
    import pp_side_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_strobe_a,
    input  logic                 ld_strobe_b,
    input  logic [BYTE_W-1:0]    side_a,
    input  logic [BYTE_W-1:0]    side_b,
    input  logic                 use_set_b,
    output logic [COL_VEC_W-1:0] col0_wts,
    output logic [COL_VEC_W-1:0] col1_wts,
    output logic [BYTE_W-1:0]    col0_exp,
    output logic [BYTE_W-1:0]    col1_exp,
    output logic [NUM_SETS-1:0]  set_ready,
    output logic                 aim_err
);

    wr_cmd_t            cmd;
    coef_set_t          bank [NUM_SETS];
    coef_set_t          live;
    logic [LANES_W-1:0] lanes;

    assign lanes = {side_b, side_a};

    pp_load_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .strobe_a (ld_strobe_a),
        .strobe_b (ld_strobe_b),
        .sel_b    (use_set_b),
        .cmd      (cmd),
        .ready    (set_ready),
        .aim_err  (aim_err)
    );

    for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
        pp_buf_set u_set (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cmd.active && (cmd.target == 1'(s))),
            .slot     (cmd.slot),
            .lanes    (lanes),
            .contents (bank[s])
        );
    end

    pp_out_sel u_sel (
        .sel_b (use_set_b),
        .set_a (bank[0]),
        .set_b (bank[1]),
        .live  (live)
    );

    assign col0_wts = live.wts[0];
    assign col1_wts = live.wts[1];
    assign col0_exp = live.expo[0];
    assign col1_exp = live.expo[1];

    AST_LIVE_SET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd.active && cmd.target != use_set_b) |=>
            (!$stable(use_set_b) || ($stable(col0_wts) && $stable(col1_wts)
                                     && $stable(col0_exp) && $stable(col1_exp)))) // R7
        else $error("live bank disturbed by background load");

endmodule

// File: tb/tb_pp_side_loader.sv
module tb_pp_side_loader;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_strobe_a, ld_strobe_b;
    logic [7:0]  side_a, side_b;
    logic        use_set_b;
    logic [79:0] col0_wts, col1_wts;
    logic [7:0]  col0_exp, col1_exp;
    logic [1:0]  set_ready;
    logic        aim_err;

    pp_side_loader dut (
        .clk         (clk),
        .rst         (rst),
        .ld_strobe_a (ld_strobe_a),
        .ld_strobe_b (ld_strobe_b),
        .side_a      (side_a),
        .side_b      (side_b),
        .use_set_b   (use_set_b),
        .col0_wts    (col0_wts),
        .col1_wts    (col1_wts),
        .col0_exp    (col0_exp),
        .col1_exp    (col1_exp),
        .set_ready   (set_ready),
        .aim_err     (aim_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] m_exp [2][2];
    logic [7:0] m_wt  [2][2][NW];
    logic [1:0] m_rdy;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         ended = 0;

    function automatic logic [79:0] flat_wts(int s, int c);
        logic [79:0] v;
        for (int k = 0; k < NW; k++) v[k*8 +: 8] = m_wt[s][c][k];
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [159:0] act, logic [159:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic chk_set(int s, string tag);
        logic [159:0] ew;
        logic [15:0]  ee;
        use_set_b = s[0];
        #1;
        ew = {flat_wts(s, 1), flat_wts(s, 0)};
        ee = {m_exp[s][1], m_exp[s][0]};
        chk({col1_wts, col0_wts} == ew, {tag, " weights"}, {col1_wts, col0_wts}, ew);
        chk({col1_exp, col0_exp} == ee, {tag, " exponents"}, {144'd0, col1_exp, col0_exp}, {144'd0, ee});
    endtask

    task automatic set_strobe(int s, bit v);
        if (s == 0) ld_strobe_a = v; else ld_strobe_b = v;
    endtask

    task automatic rand_lanes();
        side_a = 8'($urandom);
        side_b = 8'($urandom);
    endtask

    task automatic clear_model();
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++) begin
                m_exp[s][c] = 8'h00;
                for (int k = 0; k < NW; k++) m_wt[s][c][k] = 8'h00;
            end
        m_rdy = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ld_strobe_a = 0; ld_strobe_b = 0; rand_lanes();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clear_model();
        chk(set_ready == 2'b00, "R1 ready after reset", {158'd0, set_ready}, 160'd0);
        chk(aim_err == 1'b0, "R1 aim_err after reset", {159'd0, aim_err}, 160'd0);
        chk_set(0, "R1 set A zero");
        chk_set(1, "R1 set B zero");
    endtask

    task automatic run_load(int s, bit sel_v, bit short_strobe, bit poke_other);
        logic [7:0] e0, e1;
        logic [7:0] w0 [NW];
        logic [7:0] w1 [NW];
        int o;
        o  = 1 - s;
        e0 = 8'($urandom); e1 = 8'($urandom);
        for (int k = 0; k < NW; k++) begin w0[k] = 8'($urandom); w1[k] = 8'($urandom); end
        // cycle 1: start, lanes junk
        @(negedge clk);
        use_set_b = sel_v; set_strobe(s, 1'b1); rand_lanes();
        // cycle 2: exponents
        @(negedge clk);
        chk(set_ready[s] == 1'b0, "R6 ready cleared in cycle 2", {159'd0, set_ready[s]}, 160'd0);
        chk(aim_err == (s == int'(sel_v)), "R8 aim_err in cycle 2", {159'd0, aim_err}, {159'd0, (s == int'(sel_v))});
        side_a = e0; side_b = e1;
        if (short_strobe) set_strobe(s, 1'b0);
        // cycle 3: pad bytes, discarded (R3)
        @(negedge clk);
        chk(aim_err == 1'b0, "R8 aim_err one cycle", {159'd0, aim_err}, 160'd0);
        rand_lanes();
        for (int k = 0; k < NW; k++) begin
            @(negedge clk);
            if (k == 4 && s != int'(sel_v)) chk_set(int'(sel_v), "R7 live bank during load");
            use_set_b = sel_v;
            side_a = w0[k]; side_b = w1[k];
            if (k == NW - 1) set_strobe(s, 1'b0);
            if (poke_other && k == 2) set_strobe(o, 1'b1);
            if (poke_other && k == 3) set_strobe(o, 1'b0);
            if (poke_other && k == 5) set_strobe(s, 1'b1);
            if (poke_other && k == 6) set_strobe(s, 1'b0);
        end
        // cycle 14
        @(negedge clk);
        rand_lanes();
        m_exp[s][0] = e0; m_exp[s][1] = e1;
        for (int k = 0; k < NW; k++) begin m_wt[s][0][k] = w0[k]; m_wt[s][1][k] = w1[k]; end
        m_rdy[s] = 1'b1;
        chk(set_ready == m_rdy, "R5 ready in cycle 14", {158'd0, set_ready}, {158'd0, m_rdy});
        chk_set(s, "R3 R4 R5 loaded bank");
        if (poke_other) begin
            chk_set(o, "R10 other bank untouched");
            @(negedge clk);
            chk(set_ready == m_rdy, "R10 no second load", {158'd0, set_ready}, {158'd0, m_rdy});
        end
    endtask

    task automatic both_strobes();
        @(negedge clk);
        ld_strobe_a = 1; ld_strobe_b = 1; rand_lanes();
        @(negedge clk);
        chk(aim_err == 1'b0, "R9 no aim_err", {159'd0, aim_err}, 160'd0);
        ld_strobe_a = 0; ld_strobe_b = 0;
        repeat (14) begin @(negedge clk); rand_lanes(); end
        chk(set_ready == m_rdy, "R9 ready unchanged", {158'd0, set_ready}, {158'd0, m_rdy});
        chk_set(0, "R9 set A unchanged");
        chk_set(1, "R9 set B unchanged");
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20517));
        rst = 1; ld_strobe_a = 0; ld_strobe_b = 0; use_set_b = 0;
        side_a = 0; side_b = 0;
        clear_model();
        do_reset();                    // R1
        run_load(0, 1'b1, 1'b0, 1'b0); // R2 R3 R5: set A in background
        run_load(1, 1'b0, 1'b0, 1'b1); // R10: stray strobes mid-load
        run_load(0, 1'b0, 1'b0, 1'b0); // R8: aimed at live bank
        run_load(1, 1'b0, 1'b1, 1'b0); // R4: short strobe
        both_strobes();                // R9
        for (int i = 0; i < 24; i++)
            run_load(int'($urandom % 2), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        both_strobes();
        do_reset();                    // R1 after loads
        run_load(1, 1'b1, 1'b0, 1'b0);
        finish_run();
    end

endmodule